// File: doc/BRIEF.md
# Test Vector Sequencer Controller

This block steers a pattern generator through its program. Each cycle it presents one step address. That address indexes both the control memory, which holds the instruction words, and the data memory, which holds the test vectors. So every step pairs one instruction with one vector. The controller reads the instruction word that the control memory returns for the current address and decides the next address. It can step forward, wrap at a programmable last step, or jump to one of two address registers. It can also stop in a paused state or a halted state.

Any instruction can depend on a condition: always, the external event line, a one-bit X register, or its inverse. The external trigger, jump and pause inputs are qualified in the same way through a small configuration word. A register load port sets the last step, the X register and that configuration word. The state outputs report Halt, Run and Pause, and a sticky bit reports that the program stopped in Halt.

States and transitions:
- Halt → Run: a qualified trigger starts the program at address 0.
- Run → Run: the controller advances, wraps, or jumps.
- Run → Pause: a PAUSE instruction or a qualified external pause.
- Pause → Run: a resume pulse, or the release of an external pause. The program continues at the next address.
- Run → Halt: a HALT instruction.

Top module: `seq_ctrl`

## Requirements
- R1: After reset the controller is in Halt with address 0 and halt_done low. The state code is `00` for Halt, `01` for Run and `10` for Pause. Defaults: last step 255, X = 0, all external conditions "always", external jump target A.
- R2: In Halt, a qualified trigger moves to Run at address 0 and clears halt_done. An unqualified trigger leaves the state and the address unchanged.
- R3: In Run, with no external override, a NOP (or the reserved opcode 7) advances the address. The next address is address+1, or 0 when the address equals the last step.
- R4: The instruction word is laid out as opcode [12:10], condition [9:8] and address field [7:0]. The opcodes are NOP=0, LOAD_A=1, LOAD_B=2, JUMP_A=3, JUMP_B=4, PAUSE=5, HALT=6. A LOAD copies the field into register A or B and then advances. A JUMP loads the address from A or B. Both registers reset to 0.
- R5: The condition codes are 0 always, 1 external event, 2 X set, 3 X clear. An instruction whose condition is false acts as a plain advance: no load, no jump, no state change.
- R6: A true PAUSE instruction enters Pause and holds the address. Only a resume pulse leaves that Pause, and it moves to the next address in Run.
- R7: A true HALT instruction enters Halt, keeps the address and sets halt_done.
- R8: In Run, a qualified external pause has priority over everything else. It enters Pause and holds the address. That Pause ends when the qualified pause drops or a resume pulse arrives, and the program continues at the next address.
- R9: In Run, without a qualified pause, a qualified external jump loads the address from A, or from B when the target bit is set. The instruction at that step is ignored.
- R10: Register load port. Select 0 writes the last step. Select 1 writes X from data bit 0. Select 2 writes the external control word: jump condition [1:0], pause condition [3:2], trigger condition [5:4], jump target [6]. Select 3 writes nothing. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 13 | Control memory word at the current step address |
| step_addr_o | output | 8 | Step address for the control and data memories |
| ext_trig_i | input | 1 | External trigger |
| ext_jump_i | input | 1 | External jump request |
| ext_pause_i | input | 1 | External pause level |
| ext_resume_i | input | 1 | Resume pulse |
| ext_event_i | input | 1 | External event condition |
| cfg_we_i | input | 1 | Register load strobe |
| cfg_sel_i | input | 2 | Register select |
| cfg_data_i | input | 8 | Register load data |
| state_o | output | 2 | State code |
| running_o | output | 1 | In Run |
| paused_o | output | 1 | In Pause |
| halted_o | output | 1 | In Halt |
| halt_done_o | output | 1 | Set on entry to Halt, cleared by a start |

## Verification
The hardest situation to reach is a Pause entered through the external input whose qualifying condition then turns false. The condition can turn false because the event line changes, or because X is rewritten while the pause line stays high. In that case the controller must resume on its own, while a Pause entered by an instruction must not. The directed part of the bench holds the external pause over a PAUSE instruction and then releases it. The random part rewrites the pause condition and X at random while the event line toggles, so that both kinds of Pause meet changing conditions.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_LOAD_A = 3'd1,
        OP_LOAD_B = 3'd2,
        OP_JUMP_A = 3'd3,
        OP_JUMP_B = 3'd4,
        OP_PAUSE  = 3'd5,
        OP_HALT   = 3'd6,
        OP_RSVD   = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        CND_ALWAYS = 2'd0,
        CND_EVENT  = 2'd1,
        CND_X      = 2'd2,
        CND_NOTX   = 2'd3
    } cond_e;

    typedef enum logic [1:0] {
        ST_HALT  = 2'b00,
        ST_RUN   = 2'b01,
        ST_PAUSE = 2'b10
    } state_e;

    typedef enum logic [2:0] {
        AD_HOLD,
        AD_NEXT,
        AD_ZERO,
        AD_TO_A,
        AD_TO_B
    } addr_act_e;

    typedef enum logic [1:0] {
        CFG_LAST  = 2'd0,
        CFG_XREG  = 2'd1,
        CFG_EXT   = 2'd2,
        CFG_SPARE = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/seqctl_cfg.sv
module seqctl_cfg
    import seqctl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [1:0]    sel_i,
    input  logic [AW-1:0] data_i,
    output logic [AW-1:0] last_step_o,
    output logic          x_o,
    output cond_e         jmp_cond_o,
    output cond_e         pau_cond_o,
    output cond_e         trg_cond_o,
    output logic          jmp_to_b_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_step_o <= '1;
            x_o         <= 1'b0;
            jmp_cond_o  <= CND_ALWAYS;
            pau_cond_o  <= CND_ALWAYS;
            trg_cond_o  <= CND_ALWAYS;
            jmp_to_b_o  <= 1'b0;
        end else if (we_i) begin
            unique case (cfg_sel_e'(sel_i))
                CFG_LAST: last_step_o <= data_i;
                CFG_XREG: x_o <= data_i[0];
                CFG_EXT: begin
                    jmp_cond_o <= cond_e'(data_i[1:0]);
                    pau_cond_o <= cond_e'(data_i[3:2]);
                    trg_cond_o <= cond_e'(data_i[5:4]);
                    jmp_to_b_o <= data_i[6];
                end
                CFG_SPARE: ;
            endcase
        end
    end

endmodule

// File: rtl/seqctl_cond.sv
module seqctl_cond
    import seqctl_pkg::*;
(
    input  cond_e sel_i,
    input  logic  event_i,
    input  logic  x_i,
    output logic  ok_o
);

    always_comb begin
        unique case (sel_i)
            CND_ALWAYS: ok_o = 1'b1;
            CND_EVENT:  ok_o = event_i;
            CND_X:      ok_o = x_i;
            CND_NOTX:   ok_o = !x_i;
        endcase
    end

endmodule

// File: rtl/seqctl_addr.sv
module seqctl_addr
    import seqctl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  addr_act_e     act_i,
    input  logic          ld_a_i,
    input  logic          ld_b_i,
    input  logic [AW-1:0] ld_val_i,
    input  logic [AW-1:0] last_step_i,
    output logic [AW-1:0] step_o
);

    logic [AW-1:0] reg_a;
    logic [AW-1:0] reg_b;
    logic [AW-1:0] step_nxt;
    logic [AW-1:0] step_inc;

    assign step_inc = (step_o == last_step_i) ? '0 : step_o + 1'b1;

    always_comb begin
        unique case (act_i)
            AD_NEXT: step_nxt = step_inc;
            AD_ZERO: step_nxt = '0;
            AD_TO_A: step_nxt = reg_a;
            AD_TO_B: step_nxt = reg_b;
            default: step_nxt = step_o;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_o <= '0;
            reg_a  <= '0;
            reg_b  <= '0;
        end else begin
            step_o <= step_nxt;
            if (ld_a_i) reg_a <= ld_val_i;
            if (ld_b_i) reg_b <= ld_val_i;
        end
    end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seqctl_pkg::*;
#(
    parameter int AW = 8,
    localparam int IW = AW + 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] instr_i,
    output logic [AW-1:0] step_addr_o,
    input  logic          ext_trig_i,
    input  logic          ext_jump_i,
    input  logic          ext_pause_i,
    input  logic          ext_resume_i,
    input  logic          ext_event_i,
    input  logic          cfg_we_i,
    input  logic [1:0]    cfg_sel_i,
    input  logic [AW-1:0] cfg_data_i,
    output logic [1:0]    state_o,
    output logic          running_o,
    output logic          paused_o,
    output logic          halted_o,
    output logic          halt_done_o
);

    localparam int OP_LSB  = AW + 2;
    localparam int CND_LSB = AW;
    localparam int NCOND   = 4;   // instruction, trigger, jump, pause

    state_e        state_q, state_n;
    logic          pext_q, pext_n;
    logic          set_hd, clr_hd;
    addr_act_e     act;
    logic          ld_a, ld_b;
    logic [AW-1:0] last_step;
    logic          x_flag, jmp_to_b;
    cond_e         jmp_cond, pau_cond, trg_cond;
    cond_e         cond_sel [NCOND];
    logic [NCOND-1:0] cond_ok;
    opcode_e       op;
    logic          q_trig, q_jump, q_pause;

    assign op = opcode_e'(instr_i[OP_LSB +: 3]);
    assign cond_sel[0] = cond_e'(instr_i[CND_LSB +: 2]);
    assign cond_sel[1] = trg_cond;
    assign cond_sel[2] = jmp_cond;
    assign cond_sel[3] = pau_cond;

    seqctl_cfg #(.AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
        .data_i(cfg_data_i), .last_step_o(last_step), .x_o(x_flag),
        .jmp_cond_o(jmp_cond), .pau_cond_o(pau_cond), .trg_cond_o(trg_cond),
        .jmp_to_b_o(jmp_to_b)
    );

    for (genvar g = 0; g < NCOND; g++) begin : g_cond
        seqctl_cond u_cond (
            .sel_i(cond_sel[g]), .event_i(ext_event_i), .x_i(x_flag),
            .ok_o(cond_ok[g])
        );
    end

    assign q_trig  = ext_trig_i  && cond_ok[1];
    assign q_jump  = ext_jump_i  && cond_ok[2];
    assign q_pause = ext_pause_i && cond_ok[3];

    seqctl_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .act_i(act), .ld_a_i(ld_a), .ld_b_i(ld_b),
        .ld_val_i(instr_i[AW-1:0]), .last_step_i(last_step),
        .step_o(step_addr_o)
    );

    // next state and address action
    always_comb begin
        state_n = state_q;
        pext_n  = pext_q;
        act     = AD_HOLD;
        ld_a    = 1'b0;
        ld_b    = 1'b0;
        set_hd  = 1'b0;
        clr_hd  = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                if (q_trig) begin
                    state_n = ST_RUN;
                    act     = AD_ZERO;
                    clr_hd  = 1'b1;
                end
            end
            ST_RUN: begin
                if (q_pause) begin
                    state_n = ST_PAUSE;
                    pext_n  = 1'b1;
                end else if (q_jump) begin
                    act = jmp_to_b ? AD_TO_B : AD_TO_A;
                end else if (!cond_ok[0]) begin
                    act = AD_NEXT;
                end else begin
                    unique case (op)
                        OP_LOAD_A: begin ld_a = 1'b1; act = AD_NEXT; end
                        OP_LOAD_B: begin ld_b = 1'b1; act = AD_NEXT; end
                        OP_JUMP_A: act = AD_TO_A;
                        OP_JUMP_B: act = AD_TO_B;
                        OP_PAUSE: begin
                            state_n = ST_PAUSE;
                            pext_n  = 1'b0;
                        end
                        OP_HALT: begin
                            state_n = ST_HALT;
                            set_hd  = 1'b1;
                        end
                        default: act = AD_NEXT;
                    endcase
                end
            end
            ST_PAUSE: begin
                if (ext_resume_i || (pext_q && !q_pause)) begin
                    state_n = ST_RUN;
                    act     = AD_NEXT;
                end
            end
            default: state_n = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_HALT;
            pext_q      <= 1'b0;
            halt_done_o <= 1'b0;
        end else begin
            state_q <= state_n;
            pext_q  <= pext_n;
            if (set_hd)      halt_done_o <= 1'b1;
            else if (clr_hd) halt_done_o <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        state_o   = state_q;
        running_o = (state_q == ST_RUN);
        paused_o  = (state_q == ST_PAUSE);
        halted_o  = (state_q == ST_HALT);
    end

endmodule

// File: rtl/seq_ctrl_chk.sv
module seq_ctrl_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] step_addr_o,
    input logic [1:0]    state_o,
    input logic          running_o,
    input logic          paused_o,
    input logic          halted_o,
    input logic          halt_done_o
);

    assert_one_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({running_o, paused_o, halted_o}) && state_o != 2'b11);

    assert_halt_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> (!halted_o || $stable(step_addr_o)));

    assert_start_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> (!running_o || step_addr_o == '0));

    assert_run_clears_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |-> !halt_done_o);

    assert_pause_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        paused_o |=> (!paused_o || $stable(step_addr_o)));

    assert_pause_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused_o) |-> $stable(step_addr_o));

    assert_halt_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted_o) |-> (halt_done_o && $stable(step_addr_o)));

endmodule

bind seq_ctrl seq_ctrl_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .step_addr_o(step_addr_o), .state_o(state_o),
    .running_o(running_o), .paused_o(paused_o), .halted_o(halted_o),
    .halt_done_o(halt_done_o)
);

// File: tb/seq_ctrl_bench.sv
`timescale 1ns/1ps
module seq_ctrl_bench;
    localparam int AW = 8;
    localparam int IW = AW + 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic [IW-1:0] instr;
    logic [AW-1:0] step_addr, cfg_data;
    logic trig = 0, jmp = 0, pau = 0, res = 0, ev = 0, we = 0;
    logic [1:0] sel = 0, state;
    logic running, paused, halted, hd;
    logic [IW-1:0] prog [256];

    assign instr = prog[step_addr];

    seq_ctrl #(.AW(AW)) u_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .step_addr_o(step_addr),
        .ext_trig_i(trig), .ext_jump_i(jmp), .ext_pause_i(pau),
        .ext_resume_i(res), .ext_event_i(ev), .cfg_we_i(we),
        .cfg_sel_i(sel), .cfg_data_i(cfg_data), .state_o(state),
        .running_o(running), .paused_o(paused), .halted_o(halted),
        .halt_done_o(hd)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    logic [1:0] m_st = 0;
    logic [7:0] m_addr = 0, m_a = 0, m_b = 0, m_last = 8'hFF;
    logic m_hd = 0, m_pext = 0, m_x = 0, m_tgt = 0;
    logic [1:0] m_jc = 0, m_pc = 0, m_tc = 0;

    function automatic bit ce(input logic [1:0] s, input logic e, input logic x);
        case (s)
            2'd0: return 1'b1;
            2'd1: return e;
            2'd2: return x;
            default: return !x;
        endcase
    endfunction

    function automatic logic [IW-1:0] mk(input int op, input int c, input int f);
        return {op[2:0], c[1:0], f[7:0]};
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit t, input bit j, input bit p, input bit r,
                       input bit e, input bit w, input logic [1:0] s,
                       input logic [7:0] d);
        logic [IW-1:0] iw;
        logic [2:0] op;
        logic [7:0] adv, na, nA, nB;
        logic [1:0] ns;
        logic nhd, npx;
        string tag;
        @(negedge clk);
        trig = t; jmp = j; pau = p; res = r; ev = e; we = w; sel = s; cfg_data = d;
        iw = prog[m_addr]; op = iw[12:10];
        adv = (m_addr == m_last) ? 8'd0 : m_addr + 8'd1;
        ns = m_st; na = m_addr; nA = m_a; nB = m_b; nhd = m_hd; npx = m_pext;
        tag = "R2";
        case (m_st)
            2'd0: if (t && ce(m_tc, e, m_x)) begin ns = 1; na = 0; nhd = 0; end
            2'd1: begin
                if (p && ce(m_pc, e, m_x)) begin ns = 2; npx = 1; tag = "R8"; end
                else if (j && ce(m_jc, e, m_x)) begin na = m_tgt ? m_b : m_a; tag = "R9"; end
                else if (!ce(iw[9:8], e, m_x)) begin na = adv; tag = "R5"; end
                else case (op)
                    3'd1: begin nA = iw[7:0]; na = adv; tag = "R4"; end
                    3'd2: begin nB = iw[7:0]; na = adv; tag = "R4"; end
                    3'd3: begin na = m_a; tag = "R4"; end
                    3'd4: begin na = m_b; tag = "R4"; end
                    3'd5: begin ns = 2; npx = 0; tag = "R6"; end
                    3'd6: begin ns = 0; nhd = 1; tag = "R7"; end
                    default: begin na = adv; tag = "R3"; end
                endcase
            end
            default: begin
                tag = "R6";
                if (r || (m_pext && !(p && ce(m_pc, e, m_x)))) begin
                    ns = 1; na = adv; tag = r ? "R6" : "R8";
                end
            end
        endcase
        @(posedge clk); #1;
        chk(tag, "addr", int'(step_addr), int'(na));
        chk(tag, "state", int'(state), int'(ns));
        chk(tag, "halt_done", int'(hd), int'(nhd));
        m_st = ns; m_addr = na; m_a = nA; m_b = nB; m_hd = nhd; m_pext = npx;
        if (w) begin
            case (s)
                2'd0: m_last = d;
                2'd1: m_x = d[0];
                2'd2: begin m_jc = d[1:0]; m_pc = d[3:2]; m_tc = d[5:4]; m_tgt = d[6]; end
                default: ;
            endcase
            // register write checked through its effect on later cycles (R10)
            n_chk++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 2'd0, 8'd0);
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        cfg_data = 0;
        for (int i = 0; i < 256; i++) prog[i] = '0;
        prog[0]  = mk(1, 0, 20);
        prog[1]  = mk(2, 0, 30);
        prog[2]  = mk(3, 2, 0);
        prog[3]  = mk(4, 0, 0);
        prog[30] = mk(5, 0, 0);
        prog[31] = mk(0, 0, 0);
        prog[32] = mk(3, 0, 0);
        prog[20] = mk(6, 3, 0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "state", int'(state), 0);
        chk("R1", "addr", int'(step_addr), 0);
        chk("R1", "halt_done", int'(hd), 0);
        chk("R1", "halted", int'(halted), 1);

        // R10 / R2: trigger qualified by event
        cyc(0, 0, 0, 0, 0, 1, 2'd2, 8'h10);
        cyc(1, 0, 0, 0, 0, 0, 2'd0, 8'd0);      // ignored: event low
        cyc(1, 0, 0, 0, 1, 0, 2'd0, 8'd0);      // start
        idle(4);                                // load A, load B, false jump (R5), jump B
        idle(3);                                // pause (R6) and hold
        cyc(0, 0, 0, 1, 0, 0, 2'd0, 8'd0);      // resume
        idle(4);                                // NOP, jump A, halt (R7)
        chk("R7", "halt_done", int'(hd), 1);

        // external jump to B and external pause (R9, R8), last step wrap (R3)
        cyc(0, 0, 0, 0, 0, 1, 2'd2, 8'h40);
        prog[32] = mk(0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 2'd0, 8'd33);
        cyc(1, 0, 0, 0, 0, 0, 2'd0, 8'd0);
        idle(1);
        cyc(0, 1, 0, 0, 0, 0, 2'd0, 8'd0);      // jump to B = 30
        cyc(0, 0, 1, 0, 0, 0, 2'd0, 8'd0);      // external pause at PAUSE step
        cyc(0, 0, 1, 0, 0, 0, 2'd0, 8'd0);
        cyc(0, 0, 0, 0, 0, 0, 2'd0, 8'd0);      // release
        idle(3);                                // 31, 32, 33 -> wrap to 0
        chk("R3", "wrapped addr", int'(step_addr), 0);
        cyc(0, 0, 0, 0, 0, 1, 2'd1, 8'd1);      // X = 1
        idle(6);

        // random phase
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 256; i++) begin
                int r, op;
                r = $urandom % 16;
                op = (r < 5) ? 0 : (r < 7) ? 1 : (r < 9) ? 2 : (r < 11) ? 3 :
                     (r < 13) ? 4 : (r == 13) ? 5 : (r == 14) ? 6 : 7;
                prog[i] = mk(op, $urandom % 4, $urandom % 256);
            end
            for (int n = 0; n < 1000; n++) begin
                bit w;
                logic [1:0] s;
                logic [7:0] d;
                w = ($urandom % 20) == 0;
                s = 2'($urandom % 4);
                d = (s == 2'd0) ? 8'(8 + $urandom % 60) : 8'($urandom % 256);
                cyc(($urandom % 10) < 3, ($urandom % 20) == 0, ($urandom % 12) == 0,
                    ($urandom % 7) == 0, $urandom % 2, w, s, d);
            end
        end

        done = 1;
        summary();
        $finish;
    end
endmodule